// File: doc/BRIEF.md
# Serial Controller Interrupt Aggregator

This block gathers twelve event sources of a serial bus controller into one interrupt line. Ten of the sources are single-cycle pulses. Each pulse sets a sticky status bit, and that bit stays set until software clears it. The other two sources are the receive-threshold and transmit-threshold conditions. These are levels, and their status bits track the input level directly. A mask register selects which status bits can reach the combined interrupt output. A mask bit of 1 passes its source and a bit of 0 blocks it.

Software reaches the block through a simple register port: an address, a read strobe and a write strobe. Reading the masked view, the raw view, the mask or the abort-cause capture has no side effect. The sticky bits are cleared by reading, not by writing. Each sticky bit has its own clear address, and one further address clears all of them together. When a transmit abort is signalled, the cause vector that comes with it is ORed into a 16-bit capture register. That register empties in the same cycle as the abort status bit.

Top module: `irq_agg_top`

## Requirements
- R1: After a synchronous reset, the raw status, the mask, the abort-cause capture and `irq_out` are all zero.
- R2: The status bits sit at these positions: 0 rx underflow, 1 rx overflow, 2 rx threshold, 3 tx overflow, 4 tx threshold, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop, 10 start, 11 general call. A one-cycle pulse on `event_in[i]` for a sticky bit (every bit except 2 and 4) sets raw bit i at the next edge, and the bit stays set until it is cleared.
- R3: Raw bits 2 and 4 follow `event_in[2]` and `event_in[4]` in the same cycle. No clear read affects them.
- R4: A write strobe with address 0x30 loads `wr_data[11:0]` into the mask. A read of 0x30 returns the mask.
- R5: A read of 0x34 returns the raw status. A read of 0x2C returns the raw status ANDed with the mask.
- R6: A read strobe at one of these addresses clears one sticky bit at the next edge: 0x44 bit 0, 0x48 bit 1, 0x4C bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5C bit 8, 0x60 bit 9, 0x64 bit 10, 0x68 bit 11.
- R7: A read strobe at 0x40 clears every sticky bit at once and leaves bits 2 and 4 as they are.
- R8: If an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: A pulse on `event_in[6]` ORs `abort_cause` into the capture register, which reads at 0x80. Any clear of bit 6 (0x54 or 0x40) empties the capture, unless a new abort arrives in that same cycle.
- R10: `irq_out` is the OR of the masked status, delayed by one register.
- R11: A write to any address other than 0x30 changes nothing. Reads of clear addresses and of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_in | input | 12 | Event pulses (sticky bits) and threshold levels (bits 2, 4) |
| abort_cause | input | 16 | Abort cause vector, sampled when `event_in[6]` pulses |
| addr | input | 8 | Register byte address |
| rd_en | input | 1 | Read strobe; clear addresses act at the next edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 12 | Write data for the mask |
| rd_data | output | 16 | Read data, combinational while `rd_en` is high |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The interaction of interest is a new event on a sticky bit arriving in the same cycle that software reads that bit's clear address. The bench drives the pulse on `event_in[7]` together with a read strobe at 0x58. It then reads the raw view and expects bit 7 to be set. The same collision is covered by an assertion on every sticky bit. For the abort capture, two abort pulses with different causes must OR together, and a later clear must empty the capture in the same cycle as status bit 6.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_SRC  = 12;
    localparam int ABORT_W  = 16;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;

    // positions whose status follows the input level
    localparam logic [NUM_SRC-1:0] LEVEL_BITS  = 12'h014;
    localparam logic [NUM_SRC-1:0] STICKY_BITS = ~LEVEL_BITS;
    localparam int   ABORT_BIT = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_MASKED = 8'h2C,
        A_MASK   = 8'h30,
        A_RAW    = 8'h34,
        A_CLRALL = 8'h40,
        A_ABORT  = 8'h80
    } reg_addr_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
        logic [NUM_SRC-1:0] mask;
        logic [ABORT_W-1:0] cause;
    } irq_state_t;

    // per-bit clear address; all-ones result means no dedicated address
    function automatic logic [ADDR_W-1:0] clr_addr_of(input int bit_idx);
        case (bit_idx)
            0:  return 8'h44;
            1:  return 8'h48;
            3:  return 8'h4C;
            5:  return 8'h50;
            6:  return 8'h54;
            7:  return 8'h58;
            8:  return 8'h5C;
            9:  return 8'h60;
            10: return 8'h64;
            11: return 8'h68;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/irq_clr_dec.sv
module irq_clr_dec
    import irq_agg_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd_en,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic               is_clr_addr
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
        if (STICKY_BITS[i]) begin : g_st
            assign hit[i] = (addr == clr_addr_of(i));
        end else begin : g_lv
            assign hit[i] = 1'b0;
        end
    end

    always_comb begin
        is_clr_addr = (addr == A_CLRALL) || (|hit);
        if (!rd_en)
            clr_vec = '0;
        else if (addr == A_CLRALL)
            clr_vec = STICKY_BITS;
        else
            clr_vec = hit;
    end

    always_comb begin
        if (addr != A_CLRALL)
            AST_SINGLE_CLR: assert ($countones(clr_vec) <= 1); // R6
    end
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] event_in,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] raw
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (STICKY_BITS[i]) begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (event_in[i])
                    bit_q <= 1'b1;
                else if (clr_vec[i])
                    bit_q <= 1'b0;
            end
            assign raw[i] = bit_q;

            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                event_in[i] |=> raw[i]); // R8
            AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[i] && !event_in[i]) |=> !raw[i]); // R6
            AST_HOLD: assert property (@(posedge clk) disable iff (rst)
                (raw[i] && !clr_vec[i]) |=> raw[i]); // R2
        end else begin : g_level
            assign raw[i] = event_in[i];
        end
    end
endmodule

// File: rtl/irq_abort_cap.sv
module irq_abort_cap
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               abort_evt,
    input  logic               abort_clr,
    input  logic [ABORT_W-1:0] abort_cause,
    output logic [ABORT_W-1:0] cause_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else if (abort_evt)
            cause_q <= (abort_clr ? '0 : cause_q) | abort_cause;
        else if (abort_clr)
            cause_q <= '0;
    end

    AST_CAUSE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (abort_clr && !abort_evt) |=> (cause_q == '0)); // R9
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [11:0]        event_in,
    input  logic [15:0]        abort_cause,
    input  logic [7:0]         addr,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [11:0]        wr_data,
    output logic [15:0]        rd_data,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] clr_vec;
    logic               is_clr_addr;
    irq_state_t         st;
    logic [NUM_SRC-1:0] masked;
    logic               mask_we;

    irq_clr_dec u_dec (
        .addr        (addr),
        .rd_en       (rd_en),
        .clr_vec     (clr_vec),
        .is_clr_addr (is_clr_addr)
    );

    irq_status_bits u_bits (
        .clk      (clk),
        .rst      (rst),
        .event_in (event_in),
        .clr_vec  (clr_vec),
        .raw      (st.raw)
    );

    irq_abort_cap u_abort (
        .clk         (clk),
        .rst         (rst),
        .abort_evt   (event_in[ABORT_BIT]),
        .abort_clr   (clr_vec[ABORT_BIT]),
        .abort_cause (abort_cause),
        .cause_q     (st.cause)
    );

    assign mask_we = wr_en && (addr == A_MASK);

    always_ff @(posedge clk) begin
        if (rst)
            st.mask <= '0;
        else if (mask_we)
            st.mask <= wr_data;
    end

    assign masked = st.raw & st.mask;

    always_ff @(posedge clk) begin
        if (rst)
            irq_out <= 1'b0;
        else
            irq_out <= |masked;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en && !is_clr_addr) begin
            case (addr)
                A_MASKED: rd_data = DATA_W'(masked);
                A_MASK:   rd_data = DATA_W'(st.mask);
                A_RAW:    rd_data = DATA_W'(st.raw);
                A_ABORT:  rd_data = st.cause;
                default:  rd_data = '0;
            endcase
        end
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        (|(st.raw & st.mask)) |=> irq_out); // R10
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
        !(|(st.raw & st.mask)) |=> !irq_out); // R10
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_MASK) |=> $stable(st.mask)); // R11
endmodule

// File: tb/irq_agg_top_bench.sv
module irq_agg_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] event_in = '0;
    logic [15:0] abort_cause = '0;
    logic [7:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    irq_agg_top u_irq_agg_top (
        .clk(clk), .rst(rst), .event_in(event_in), .abort_cause(abort_cause),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    // monitor: compares read data against the scoreboard mid-cycle
    always @(negedge clk) begin
        if (rd_en && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                failures++;
                $display("FAIL %s addr=%h got=%h exp=%h", t, addr, rd_data, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [11:0] d);
        @(posedge clk); #1;
        addr = a; wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] bits);
        @(posedge clk); #1;
        event_in = event_in | bits;
        @(posedge clk); #1;
        event_in = event_in & ~bits;
    endtask

    task automatic chk_irq(input logic e, input string t);
        repeat (2) @(posedge clk);
        #2;
        checks++;
        if (irq_out !== e) begin
            failures++;
            $display("FAIL %s irq_out got=%b exp=%b", t, irq_out, e);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        rd(8'h34, 16'h000, "R1 raw");
        rd(8'h30, 16'h000, "R1 mask");
        rd(8'h80, 16'h000, "R1 cause");
        chk_irq(1'b0, "R1");
        // R2 sticky set, mask 0 blocks
        pulse(12'h00B);
        rd(8'h34, 16'h00B, "R2 raw");
        rd(8'h34, 16'h00B, "R2 held");
        rd(8'h2C, 16'h000, "R5 masked by zero");
        chk_irq(1'b0, "R10 masked off");
        // R4 mask write
        wr(8'h30, 12'hFFF);
        rd(8'h30, 16'hFFF, "R4 mask");
        rd(8'h2C, 16'h00B, "R5 masked");
        chk_irq(1'b1, "R10 on");
        // R3 level bit follows input
        @(posedge clk); #1 event_in[2] = 1'b1;
        rd(8'h34, 16'h00F, "R3 level high");
        @(posedge clk); #1 event_in[2] = 1'b0;
        rd(8'h34, 16'h00B, "R3 level low");
        // R6 individual clears
        rd(8'h48, 16'h000, "R6 clear read data");
        rd(8'h34, 16'h009, "R6 bit1 cleared");
        rd(8'h44, 16'h000, "R6 clear read data");
        rd(8'h34, 16'h008, "R6 bit0 cleared");
        // R11 write elsewhere, unmapped read
        wr(8'h34, 12'h000);
        wr(8'h2C, 12'h000);
        rd(8'h34, 16'h008, "R11 raw unchanged");
        rd(8'h30, 16'hFFF, "R11 mask unchanged");
        rd(8'h3C, 16'h000, "R11 unmapped");
        // R9 abort capture
        abort_cause = 16'h1001;
        pulse(12'h040);
        abort_cause = 16'h0002;
        pulse(12'h040);
        abort_cause = 16'h0000;
        rd(8'h80, 16'h1003, "R9 cause ORed");
        rd(8'h34, 16'h048, "R9 raw bit6");
        rd(8'h54, 16'h000, "R9 clear");
        rd(8'h80, 16'h0000, "R9 cause emptied");
        rd(8'h34, 16'h008, "R9 bit6 cleared");
        // R8 collision: pulse with clear of same bit
        @(posedge clk); #1;
        addr = 8'h58; rd_en = 1'b1; event_in[7] = 1'b1;
        exp_q.push_back(16'h000); tag_q.push_back("R8 clear read data");
        @(posedge clk); #1;
        rd_en = 1'b0; event_in[7] = 1'b0;
        rd(8'h34, 16'h088, "R8 set wins");
        // R7 clear all keeps level bit
        @(posedge clk); #1 event_in[4] = 1'b1;
        pulse(12'hE20);
        rd(8'h34, 16'hEB8, "R7 before");
        rd(8'h40, 16'h000, "R7 clear read data");
        rd(8'h34, 16'h010, "R7 after");
        chk_irq(1'b1, "R10 level source");
        @(posedge clk); #1 event_in[4] = 1'b0;
        chk_irq(1'b0, "R10 all clear");
        // R10 partial mask
        wr(8'h30, 12'h001);
        pulse(12'h002);
        rd(8'h34, 16'h002, "R2 bit1");
        rd(8'h2C, 16'h000, "R5 partial mask");
        chk_irq(1'b0, "R10 blocked");
        pulse(12'h001);
        rd(8'h2C, 16'h001, "R5 passed bit");
        chk_irq(1'b1, "R10 passed");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 got=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule